// File: doc/BRIEF.md
# I2C Control Register and Event Interrupt Unit

This block sits between a CPU register port and a bit-level I2C engine. It keeps the control byte of a byte-oriented I2C peripheral that can run as master or as slave. It turns the software's start and stop bits into requests for the engine. Its meaning changes with the mode: in master mode a start bit asks for a repeated start, and in slave mode it asks for a start once the bus goes idle. A stop bit asks for a stop condition in master mode, and in slave mode it releases both lines until a start or stop is seen on the bus.

The block also tells the engine whether to acknowledge received address and data bytes, and whether to acknowledge a general-call address. Bus event strobes from the engine are merged into one interrupt. The interrupt is raised only while interrupt enable is set. For most event causes the block also asks the engine to stretch SCL low until software services the event. Two causes are exempt: lost arbitration and a stop detected in slave mode. The peripheral-enable bit switches the shared pins to the I2C function. Clearing it drops every control bit except the stop request and releases all bus outputs.

Top module: `i2c_ctl_unit`

## Requirements
- R1: After reset, reg_rdata_o is 8'h00 and every output is 0.
- R2: The register reads back with enable at bit 5, general-call enable at bit 4, start at bit 3, ack at bit 2, stop at bit 1 and interrupt enable at bit 0. Bits 7:6 always read 0. A write with bit 5 set loads bits 5:0 as written.
- R3: A write with bit 5 clear ignores bits 4, 3, 2 and 0, which become 0. Bit 1 takes the written value. Any pending interrupt is dropped.
- R4: pin_en_o equals the enable bit. While enable is 0, start_req_o, stop_req_o, slave_release_o, ack_o, gcall_ack_o, scl_hold_o and irq_o are all 0.
- R5: With the start bit set in slave mode (master_i=0), start_req_o is 1 only while bus_busy_i is 0. In master mode, start_req_o is 1 whatever the value of bus_busy_i.
- R6: A start_sent_i strobe clears the start bit at the next clock edge.
- R7: The stop bit drives stop_req_o in master mode and is cleared by stop_sent_i. In slave mode it drives slave_release_o and is cleared by start_det_i or stop_det_i.
- R8: ack_o is enable AND ack bit. gcall_ack_o additionally needs the general-call enable bit.
- R9: With interrupt enable set, irq_o rises one cycle after any of these strobes: start_sent_i in master mode, addr_match_i while the ack bit is 1, byte_evt_i, arb_lost_i in master mode, misplaced_i, nack_i, or stop_det_i in slave mode. An addr_match_i that comes with gcall_i counts only if the general-call enable bit is set. With interrupt enable clear, irq_o stays 0.
- R10: scl_hold_o is 1 while an interrupt is pending from any cause except arbitration loss and slave stop detection.
- R11: A register write clears the pending interrupt and the SCL hold. The irq_clr_i strobe also clears them, except when a new cause arrives in the same cycle; then the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| master_i | input | 1 | Engine is in master mode |
| bus_busy_i | input | 1 | Bus is between a start and a stop |
| start_sent_i | input | 1 | Engine sent a start condition |
| stop_sent_i | input | 1 | Engine sent a stop condition |
| start_det_i | input | 1 | Start condition seen on the bus |
| stop_det_i | input | 1 | Stop condition seen on the bus |
| addr_match_i | input | 1 | Received address matched |
| gcall_i | input | 1 | Matched address is the general call |
| byte_evt_i | input | 1 | Byte received or due to be sent |
| arb_lost_i | input | 1 | Arbitration lost |
| misplaced_i | input | 1 | Misplaced start or stop seen |
| nack_i | input | 1 | No acknowledge received |
| irq_clr_i | input | 1 | Software acknowledges the event |
| start_req_o | output | 1 | Request a start or repeated start |
| stop_req_o | output | 1 | Request a stop condition (master) |
| slave_release_o | output | 1 | Release SCL and SDA (slave recovery) |
| ack_o | output | 1 | Acknowledge received bytes |
| gcall_ack_o | output | 1 | Acknowledge the general-call address |
| pin_en_o | output | 1 | Route shared pins to the I2C function |
| scl_hold_o | output | 1 | Stretch SCL low |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- All bus outputs are released while the peripheral is disabled.
- A slave start request never coincides with a busy bus.
- An SCL hold never occurs without an interrupt.
- An interrupt never occurs without interrupt enable.
- A write is read back masked.
- Start and stop self-clear on their strobes.
- A write clears the pending interrupt.

Some behaviours show only in the bench's scenarios:
- The list of causes that raise the interrupt, and which of them stretch SCL.
- That addresses go unacknowledged while ack is clear, and that the general call is filtered.
- That a disabling write keeps only the stop bit.
- That a clear strobe loses to a new event arriving in the same cycle.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int POS_EN  = 5;
  localparam int POS_GC  = 4;
  localparam int POS_STA = 3;
  localparam int POS_ACK = 2;
  localparam int POS_STO = 1;
  localparam int POS_ITE = 0;
  localparam int FIELD_W = 6;

  typedef struct packed {
    logic en;
    logic gc;
    logic sta;
    logic ack;
    logic sto;
    logic ite;
  } ctl_t;

  typedef struct packed {
    logic start_sent;
    logic stop_sent;
    logic start_det;
    logic stop_det;
    logic addr_match;
    logic gcall;
    logic byte_evt;
    logic arb_lost;
    logic misplaced;
    logic nack;
  } evt_t;
endpackage

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
  import i2c_ctl_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             master_i,
  input  evt_t             evt_i,
  output ctl_t             ctl_o,
  output logic [REG_W-1:0] rdata_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_i) begin
      if (wdata_i[POS_EN]) begin
        ctl_q.en  <= 1'b1;
        ctl_q.gc  <= wdata_i[POS_GC];
        ctl_q.sta <= wdata_i[POS_STA];
        ctl_q.ack <= wdata_i[POS_ACK];
        ctl_q.sto <= wdata_i[POS_STO];
        ctl_q.ite <= wdata_i[POS_ITE];
      end else begin
        // disabled: only the stop request survives
        ctl_q     <= '0;
        ctl_q.sto <= wdata_i[POS_STO];
      end
    end else begin
      if (evt_i.start_sent) ctl_q.sta <= 1'b0;
      if (master_i && evt_i.stop_sent) ctl_q.sto <= 1'b0;
      if (!master_i && (evt_i.start_det || evt_i.stop_det)) ctl_q.sto <= 1'b0;
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[POS_EN]  = ctl_q.en;
    rdata_o[POS_GC]  = ctl_q.gc;
    rdata_o[POS_STA] = ctl_q.sta;
    rdata_o[POS_ACK] = ctl_q.ack;
    rdata_o[POS_STO] = ctl_q.sto;
    rdata_o[POS_ITE] = ctl_q.ite;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/i2c_ctl_evt.sv
module i2c_ctl_evt
  import i2c_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t ctl_i,
  input  logic master_i,
  input  evt_t evt_i,
  input  logic wr_i,
  input  logic clr_i,
  output logic irq_o,
  output logic hold_o
);
  logic hold_cause, free_cause, addr_ok;
  logic pend_hold_q, pend_free_q;

  assign addr_ok    = evt_i.addr_match && ctl_i.ack && (!evt_i.gcall || ctl_i.gc);
  assign hold_cause = ctl_i.en && ((evt_i.start_sent && master_i) || addr_ok ||
                      evt_i.byte_evt || evt_i.misplaced || evt_i.nack);
  assign free_cause = ctl_i.en && ((evt_i.arb_lost && master_i) ||
                      (evt_i.stop_det && !master_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_hold_q <= 1'b0;
      pend_free_q <= 1'b0;
    end else if (wr_i || !ctl_i.en) begin
      pend_hold_q <= 1'b0;
      pend_free_q <= 1'b0;
    end else begin
      pend_hold_q <= (pend_hold_q && !clr_i) || (ctl_i.ite && hold_cause);
      pend_free_q <= (pend_free_q && !clr_i) || (ctl_i.ite && free_cause);
    end
  end

  assign irq_o  = pend_hold_q || pend_free_q;
  assign hold_o = pend_hold_q;
endmodule

// File: rtl/i2c_ctl_req.sv
module i2c_ctl_req
  import i2c_ctl_pkg::*;
(
  input  ctl_t ctl_i,
  input  logic master_i,
  input  logic bus_busy_i,
  output logic start_req_o,
  output logic stop_req_o,
  output logic slave_release_o,
  output logic ack_o,
  output logic gcall_ack_o,
  output logic pin_en_o
);
  always_comb begin
    start_req_o     = ctl_i.en && ctl_i.sta && (master_i || !bus_busy_i);
    stop_req_o      = ctl_i.en && ctl_i.sto && master_i;
    slave_release_o = ctl_i.en && ctl_i.sto && !master_i;
    ack_o           = ctl_i.en && ctl_i.ack;
    gcall_ack_o     = ctl_i.en && ctl_i.ack && ctl_i.gc;
    pin_en_o        = ctl_i.en;
  end
endmodule

// File: rtl/i2c_ctl_unit.sv
module i2c_ctl_unit
  import i2c_ctl_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             master_i,
  input  logic             bus_busy_i,
  input  logic             start_sent_i,
  input  logic             stop_sent_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             addr_match_i,
  input  logic             gcall_i,
  input  logic             byte_evt_i,
  input  logic             arb_lost_i,
  input  logic             misplaced_i,
  input  logic             nack_i,
  input  logic             irq_clr_i,
  output logic             start_req_o,
  output logic             stop_req_o,
  output logic             slave_release_o,
  output logic             ack_o,
  output logic             gcall_ack_o,
  output logic             pin_en_o,
  output logic             scl_hold_o,
  output logic             irq_o
);
  ctl_t ctl;
  evt_t evt;
  logic hold;

  assign evt = '{start_sent: start_sent_i, stop_sent: stop_sent_i,
                 start_det: start_det_i, stop_det: stop_det_i,
                 addr_match: addr_match_i, gcall: gcall_i,
                 byte_evt: byte_evt_i, arb_lost: arb_lost_i,
                 misplaced: misplaced_i, nack: nack_i};

  i2c_ctl_reg #(.REG_W(REG_W)) i_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .master_i (master_i),
    .evt_i    (evt),
    .ctl_o    (ctl),
    .rdata_o  (reg_rdata_o)
  );

  i2c_ctl_evt i_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .master_i (master_i),
    .evt_i    (evt),
    .wr_i     (reg_wr_i),
    .clr_i    (irq_clr_i),
    .irq_o    (irq_o),
    .hold_o   (hold)
  );

  i2c_ctl_req i_req (
    .ctl_i           (ctl),
    .master_i        (master_i),
    .bus_busy_i      (bus_busy_i),
    .start_req_o     (start_req_o),
    .stop_req_o      (stop_req_o),
    .slave_release_o (slave_release_o),
    .ack_o           (ack_o),
    .gcall_ack_o     (gcall_ack_o),
    .pin_en_o        (pin_en_o)
  );

  assign scl_hold_o = hold;
endmodule

// File: rtl/i2c_ctl_unit_chk.sv
module i2c_ctl_unit_chk #(
  parameter int REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             master_i,
  input logic             bus_busy_i,
  input logic             start_sent_i,
  input logic             stop_sent_i,
  input logic             irq_clr_i,
  input logic             start_req_o,
  input logic             stop_req_o,
  input logic             slave_release_o,
  input logic             scl_hold_o,
  input logic             irq_o,
  input logic             pin_en_o
);
  a_r4_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_en_o |-> !(start_req_o || stop_req_o || slave_release_o || scl_hold_o || irq_o));

  a_r5_slave_start_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req_o && !master_i) |-> !bus_busy_i);

  a_r10_hold_needs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_hold_o |-> irq_o);

  a_r9_irq_needs_ite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> reg_rdata_o[0]);

  a_r2_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_wdata_i[5]) |=> (reg_rdata_o == {2'b00, $past(reg_wdata_i[5:0])}));

  a_r6_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_sent_i && !reg_wr_i) |=> !reg_rdata_o[3]);

  a_r7_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && stop_sent_i && !reg_wr_i) |=> !reg_rdata_o[1]);

  a_r11_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> !irq_o);
endmodule

bind i2c_ctl_unit i2c_ctl_unit_chk #(.REG_W(REG_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_wr_i        (reg_wr_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_rdata_o     (reg_rdata_o),
  .master_i        (master_i),
  .bus_busy_i      (bus_busy_i),
  .start_sent_i    (start_sent_i),
  .stop_sent_i     (stop_sent_i),
  .irq_clr_i       (irq_clr_i),
  .start_req_o     (start_req_o),
  .stop_req_o      (stop_req_o),
  .slave_release_o (slave_release_o),
  .scl_hold_o      (scl_hold_o),
  .irq_o           (irq_o),
  .pin_en_o        (pin_en_o)
);

// File: tb/test_i2c_ctl_unit.sv
module test_i2c_ctl_unit;
  localparam int CLK_PERIOD = 10;

  // event mask bits
  localparam int E_STA_SENT = 0, E_STO_SENT = 1, E_STA_DET = 2, E_STO_DET = 3,
                 E_ADDR = 4, E_GCALL = 5, E_BYTE = 6, E_ARB = 7, E_MISP = 8, E_NACK = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic master = 1'b0, busy = 1'b0, clr = 1'b0;
  logic [9:0] ev = '0;
  logic start_req, stop_req, slv_rel, ack, gack, pin_en, hold, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ctl_unit i_i2c_ctl_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .master_i(master), .bus_busy_i(busy),
    .start_sent_i(ev[E_STA_SENT]), .stop_sent_i(ev[E_STO_SENT]),
    .start_det_i(ev[E_STA_DET]), .stop_det_i(ev[E_STO_DET]),
    .addr_match_i(ev[E_ADDR]), .gcall_i(ev[E_GCALL]), .byte_evt_i(ev[E_BYTE]),
    .arb_lost_i(ev[E_ARB]), .misplaced_i(ev[E_MISP]), .nack_i(ev[E_NACK]),
    .irq_clr_i(clr), .start_req_o(start_req), .stop_req_o(stop_req),
    .slave_release_o(slv_rel), .ack_o(ack), .gcall_ack_o(gack), .pin_en_o(pin_en),
    .scl_hold_o(hold), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] m, input logic c);
    ev = m; clr = c;
    @(negedge clk);
    ev = '0; clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 outs", {start_req, stop_req, slv_rel, ack, gack, pin_en, hold, irq}, 8'h00);
  endtask

  task automatic t_readback;
    master = 1'b1;
    write(8'hFF);
    chk("R2 readback", rdata, 8'h3F);
    chk("R4 pin_en", {7'd0, pin_en}, 8'h01);
    write(8'h1F);
    chk("R3 pe off keeps stop only", rdata, 8'h02);
    chk("R4 released", {start_req, stop_req, slv_rel, ack, gack, pin_en, hold, irq}, 8'h00);
    write(8'h00);
  endtask

  task automatic t_start;
    master = 1'b0; busy = 1'b1;
    write(8'h28);
    chk("R5 slave start waits busy", {7'd0, start_req}, 8'h00);
    busy = 1'b0; #1;
    chk("R5 slave start idle", {7'd0, start_req}, 8'h01);
    pulse(10'b1 << E_STA_SENT, 1'b0);
    chk("R6 start self clear", rdata, 8'h20);
    master = 1'b1; busy = 1'b1;
    write(8'h28);
    chk("R5 master repeated start", {7'd0, start_req}, 8'h01);
    write(8'h00);
  endtask

  task automatic t_stop;
    master = 1'b1;
    write(8'h22);
    chk("R7 master stop", {6'd0, stop_req, slv_rel}, 8'h02);
    pulse(10'b1 << E_STO_SENT, 1'b0);
    chk("R7 master stop clears", rdata, 8'h20);
    master = 1'b0;
    write(8'h22);
    chk("R7 slave release", {6'd0, stop_req, slv_rel}, 8'h01);
    pulse(10'b1 << E_STA_DET, 1'b0);
    chk("R7 slave release clears", rdata, 8'h20);
    write(8'h00);
  endtask

  task automatic t_ack;
    write(8'h24);
    chk("R8 ack no gc", {6'd0, ack, gack}, 8'h02);
    write(8'h34);
    chk("R8 ack gc", {6'd0, ack, gack}, 8'h03);
    write(8'h30);
    chk("R8 no ack", {6'd0, ack, gack}, 8'h00);
    write(8'h00);
  endtask

  task automatic t_irq;
    master = 1'b0;
    write(8'h21);
    pulse(10'b1 << E_ADDR, 1'b0);
    chk("R9 addr ignored ack=0", {6'd0, irq, hold}, 8'h00);
    write(8'h25);
    pulse(10'b1 << E_ADDR, 1'b0);
    chk("R9 R10 addr irq hold", {6'd0, irq, hold}, 8'h03);
    pulse('0, 1'b1);
    chk("R11 clr strobe", {6'd0, irq, hold}, 8'h00);
    pulse((10'b1 << E_ADDR) | (10'b1 << E_GCALL), 1'b0);
    chk("R9 gcall filtered", {6'd0, irq, hold}, 8'h00);
    pulse(10'b1 << E_BYTE, 1'b0);
    chk("R9 byte irq", {6'd0, irq, hold}, 8'h03);
    write(8'h25);
    chk("R11 write clears", {6'd0, irq, hold}, 8'h00);
    pulse(10'b1 << E_STO_DET, 1'b0);
    chk("R10 slave stop no hold", {6'd0, irq, hold}, 8'h02);
    pulse('0, 1'b1);
    master = 1'b1;
    pulse(10'b1 << E_ARB, 1'b0);
    chk("R10 arb lost no hold", {6'd0, irq, hold}, 8'h02);
    pulse('0, 1'b1);
    pulse(10'b1 << E_NACK, 1'b0);
    chk("R9 nack irq", {6'd0, irq, hold}, 8'h03);
    pulse(10'b1 << E_MISP, 1'b1);
    chk("R11 clr loses to event", {6'd0, irq, hold}, 8'h03);
    write(8'h24);
    pulse(10'b1 << E_BYTE, 1'b0);
    chk("R9 ite off", {6'd0, irq, hold}, 8'h00);
    write(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_start();
    t_stop();
    t_ack();
    t_irq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule